// File: doc/BRIEF.md
# Six-Stage Tag Pipeline with Two-Cycle Execute

This block is a cycle-accurate timing model of an in-order instruction pipeline with six stages. It carries only an instruction tag through the stages. No instruction is decoded. Stage four is the execute stage, and each instruction stays there for two clock cycles. The build parameter `EXEC_UNITS` chooses between two layouts. With one execute unit, the three stages in front of it freeze while the unit is busy. With two execute units, instructions go to the units in strict alternation and the front stages never wait.

Tags enter through a valid/ready port. A tag is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the state of the pipeline and never on `in_valid`. While `in_ready` is low, the source must keep presenting the same tag. The last stage has no back-pressure. Each tag leaves as a one-cycle pulse on `out_valid`, with the tag on `out_tag`.

`cycle_count` reports how long the current batch has taken. A batch begins when a tag is taken into an empty pipeline. The count covers every cycle from the first cycle the first tag sits in S1 up to and including the cycle the last tag sits in S6. After the batch drains, the count holds its value.

Top module: `exec_stall_pipe`

## Requirements
- R1: While reset is asserted, and right after it, every stage is empty, `out_valid` is 0, `cycle_count` is 0 and `in_ready` is 1. This holds even when reset arrives in the middle of a batch.
- R2: Every accepted tag leaves on `out_tag` exactly once, as a single-cycle `out_valid` pulse. Tags leave in the order they were accepted, with or without gaps in the input.
- R3: A tag is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`.
- R4: The execute stage holds each instruction for exactly two cycles. A lone tag therefore occupies the pipeline for 7 cycles, and `cycle_count` reads 7 afterwards.
- R5: With `EXEC_UNITS`=1, S1–S3 hold their contents and `in_ready` is 0 in every cycle in which S3 holds a tag and the unit is in its first execute cycle. A back-to-back batch of n tags sees exactly n-1 such cycles and takes 6+2n-1 cycles.
- R6: With `EXEC_UNITS`=2, tags go to the two units in strict alternation. `in_ready` never falls, and a back-to-back batch of n tags takes 6+n cycles.
- R7: `cycle_count` counts the cycles from the first cycle the first tag sits in S1 through the cycle the last tag sits in S6. It then holds its value while the pipeline is empty.
- R8: When a tag is accepted into an empty pipeline, a new batch starts and the count restarts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A tag is offered |
| in_ready | output | 1 | The pipeline can take a tag this cycle |
| in_tag | input | TAG_W | Offered tag |
| out_valid | output | 1 | One-cycle completion pulse from S6 |
| out_tag | output | TAG_W | Tag that is completing |
| cycle_count | output | CNT_W | Cycles used by the current or most recent batch |

## Verification
One instance of each variant runs side by side. Back-to-back batches of 1, 2, 5 and 12 tags check the cycle formulas. If the design took 2n+5 cycles in dual mode, or failed to stall in single mode, the count would be wrong. If a stall were one cycle too long or too short, the number of cycles with `in_ready` low would not be n-1. Random gaps in the input check that tags are neither lost nor duplicated when a hold lands on a bubble. They also check that they do not leave out of order when the alternation skips a free unit. A reset in the middle of a batch must leave no stray completion pulse and must leave the count at zero. Consecutive batches check that the count restarts at 1 and does not keep accumulating.

// File: rtl/pipe6_pkg.sv
`timescale 1ns/1ps
package pipe6_pkg;
  localparam int STAGES      = 6;
  localparam int FRONT_DEPTH = 3;
  typedef enum logic {PH_FIRST = 1'b0, PH_LAST = 1'b1} xphase_t;
endpackage

// File: rtl/pipe6_front.sv
`timescale 1ns/1ps
// Stages S1..S3: a shift chain that freezes as a whole when hold is set.
module pipe6_front #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             tail_valid,
  output logic [TAG_W-1:0] tail_tag,
  output logic             any_valid
);
  logic             sv [DEPTH];
  logic [TAG_W-1:0] st [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    logic             nv;
    logic [TAG_W-1:0] nt;
    if (j == 0) begin : g_head
      assign nv = in_valid;
      assign nt = in_tag;
    end else begin : g_body
      assign nv = sv[j-1];
      assign nt = st[j-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sv[j] <= 1'b0;
      else if (!hold) sv[j] <= nv;
    end
    always_ff @(posedge clk) begin
      if (!hold) st[j] <= nt;
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int j = 0; j < DEPTH; j++) any_valid = any_valid | sv[j];
  end

  assign tail_valid = sv[DEPTH-1];
  assign tail_tag   = st[DEPTH-1];
endmodule

// File: rtl/pipe6_exec_unit.sv
`timescale 1ns/1ps
// One execute unit: keeps each instruction for exactly two cycles.
module pipe6_exec_unit
  import pipe6_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  output logic             busy,
  output logic             last,
  output logic             done,
  output logic [TAG_W-1:0] done_tag,
  output logic             can_take
);
  logic             v_q;
  xphase_t          ph_q;
  logic [TAG_W-1:0] tag_q;

  assign busy     = v_q;
  assign last     = v_q && (ph_q == PH_LAST);
  assign done     = last;
  assign done_tag = tag_q;
  assign can_take = !v_q || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      ph_q <= PH_FIRST;
    end else if (start) begin
      v_q  <= 1'b1;
      ph_q <= PH_FIRST;
    end else if (last) begin
      v_q  <= 1'b0;
      ph_q <= PH_FIRST;
    end else if (v_q) begin
      ph_q <= PH_LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (start) tag_q <= start_tag;
  end
endmodule

// File: rtl/pipe6_cyc_counter.sv
`timescale 1ns/1ps
// Batch cycle counter: counts occupied cycles and restarts at a new batch.
module pipe6_cyc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             batch_start,
  input  logic             occupied,
  output logic [CNT_W-1:0] count
);
  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      count   <= '0;
    end else begin
      first_q <= batch_start;
      if (occupied) count <= first_q ? CNT_W'(1) : count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/exec_stall_pipe.sv
`timescale 1ns/1ps
module exec_stall_pipe
  import pipe6_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 16,
  parameter int EXEC_UNITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int NU = (EXEC_UNITS > 1) ? 2 : 1;

  logic             s3_valid, front_any, stall, dispatch, in_fire, occ_any;
  logic [TAG_W-1:0] s3_tag;
  logic             sel_q;
  logic [NU-1:0]    u_valid, u_last, u_done, u_take, u_start;
  logic [TAG_W-1:0] u_tag [NU];
  logic             s5_in_v, s5_valid, s6_valid;
  logic [TAG_W-1:0] s5_in_tag, s5_tag, s6_tag;

  assign stall    = s3_valid && !u_take[sel_q];
  assign in_ready = !stall;
  assign in_fire  = in_valid && in_ready;
  assign dispatch = s3_valid && !stall;

  pipe6_front #(.TAG_W(TAG_W), .DEPTH(FRONT_DEPTH)) u_front (
    .clk(clk), .rst_n(rst_n), .hold(stall),
    .in_valid(in_valid), .in_tag(in_tag),
    .tail_valid(s3_valid), .tail_tag(s3_tag), .any_valid(front_any)
  );

  if (NU > 1) begin : g_alt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sel_q <= 1'b0;
      else if (dispatch) sel_q <= !sel_q;
    end
  end else begin : g_one
    assign sel_q = 1'b0;
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign u_start[u] = dispatch && (sel_q == 1'(u));
    pipe6_exec_unit #(.TAG_W(TAG_W)) u_exec (
      .clk(clk), .rst_n(rst_n),
      .start(u_start[u]), .start_tag(s3_tag),
      .busy(u_valid[u]), .last(u_last[u]),
      .done(u_done[u]), .done_tag(u_tag[u]), .can_take(u_take[u])
    );
  end

  always_comb begin
    s5_in_v   = 1'b0;
    s5_in_tag = '0;
    for (int u = 0; u < NU; u++) begin
      if (u_done[u]) begin
        s5_in_v   = 1'b1;
        s5_in_tag = s5_in_tag | u_tag[u];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s5_valid <= 1'b0;
      s6_valid <= 1'b0;
    end else begin
      s5_valid <= s5_in_v;
      s6_valid <= s5_valid;
    end
  end

  always_ff @(posedge clk) begin
    s5_tag <= s5_in_tag;
    s6_tag <= s5_tag;
  end

  assign out_valid = s6_valid;
  assign out_tag   = s6_tag;
  assign occ_any   = front_any || (|u_valid) || s5_valid || s6_valid;

  pipe6_cyc_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .batch_start(in_fire && !occ_any), .occupied(occ_any),
    .count(cycle_count)
  );
endmodule

// File: rtl/exec_stall_pipe_chk.sv
`timescale 1ns/1ps
module exec_stall_pipe_chk #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16,
  parameter int NU    = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic [CNT_W-1:0] cycle_count,
  input logic             s3_valid,
  input logic [TAG_W-1:0] s3_tag,
  input logic             s5_valid,
  input logic             occ_any,
  input logic [NU-1:0]    u_valid,
  input logic [NU-1:0]    u_last,
  input logic [NU-1:0]    u_done
);
  // R2: at most one unit completes per cycle, and S5 feeds S6 one cycle later
  p_one_done_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(u_done));
  p_s5_to_out_r2: assert property (@(posedge clk) disable iff (!rst_n) s5_valid |=> out_valid);
  p_no_stray_out_r2: assert property (@(posedge clk) disable iff (!rst_n) !s5_valid |=> !out_valid);

  // R4: a unit in its first cycle is in its last cycle next
  for (genvar u = 0; u < NU; u++) begin : g_u
    p_two_cycles_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (u_valid[u] && !u_last[u]) |=> (u_valid[u] && u_last[u]));
  end

  // R5: while not ready, S3 keeps its tag
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (s3_valid && $stable(s3_tag)));

  // R6: two units never hold back the input
  if (NU > 1) begin : g_dual
    p_never_stall_r6: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
  end

  // R7: count holds while the pipeline is empty
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !occ_any |=> $stable(cycle_count));
endmodule

bind exec_stall_pipe exec_stall_pipe_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W), .NU(NU)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .cycle_count(cycle_count), .s3_valid(s3_valid), .s3_tag(s3_tag),
  .s5_valid(s5_valid), .occ_any(occ_any), .u_valid(u_valid),
  .u_last(u_last), .u_done(u_done)
);

// File: tb/tb_exec_stall_pipe.sv
`timescale 1ns/1ps
module tb_exec_stall_pipe;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;
  localparam int K     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             v  [2];
  logic [TAG_W-1:0] tg [2];
  logic             rdy[2];
  logic             ov [2];
  logic [TAG_W-1:0] ot [2];
  logic [CNT_W-1:0] cc [2];

  int n_checks = 0;
  int n_fail   = 0;

  exec_stall_pipe #(.TAG_W(TAG_W), .CNT_W(CNT_W), .EXEC_UNITS(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v[0]), .in_ready(rdy[0]), .in_tag(tg[0]),
    .out_valid(ov[0]), .out_tag(ot[0]), .cycle_count(cc[0]));

  exec_stall_pipe #(.TAG_W(TAG_W), .CNT_W(CNT_W), .EXEC_UNITS(2)) dut_dual (
    .clk(clk), .rst_n(rst_n), .in_valid(v[1]), .in_ready(rdy[1]), .in_tag(tg[1]),
    .out_valid(ov[1]), .out_tag(ot[1]), .cycle_count(cc[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int units, input int n);
    return (units == 1) ? (K + 2 * n - 1) : (K + n);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // Feed n tags to both variants; check order, stalls and cycle counts.
  task automatic run_batch(input int n, input int gap_pct, input bit exact);
    logic [TAG_W-1:0] stim[$];
    int idx[2], got[2], low[2];
    bit pend[2];
    int guard = 0;
    bit bad_tag[2];
    for (int i = 0; i < n; i++) stim.push_back(TAG_W'($urandom));
    for (int d = 0; d < 2; d++) begin
      idx[d] = 0; got[d] = 0; low[d] = 0; pend[d] = 0; bad_tag[d] = 0;
    end
    while ((got[0] < n || got[1] < n) && guard < 2000) begin
      @(negedge clk);
      guard++;
      for (int d = 0; d < 2; d++) begin
        if (ov[d]) begin
          if (got[d] >= n) begin
            chk(0, "R2 extra output", got[d] + 1, n);
          end else begin
            if (ot[d] !== stim[got[d]]) begin
              chk(0, "R2 tag order", int'(ot[d]), int'(stim[got[d]]));
              bad_tag[d] = 1;
            end
            got[d]++;
          end
        end
        if (pend[d]) idx[d]++;
        if (!rdy[d]) low[d]++;
        if (idx[d] < n && int'($urandom % 100) >= gap_pct) begin
          v[d] = 1'b1; tg[d] = stim[idx[d]];
        end else begin
          v[d] = 1'b0;
        end
        pend[d] = v[d] && rdy[d];
      end
    end
    for (int d = 0; d < 2; d++) begin
      chk(got[d] == n && !bad_tag[d], "R2 all tags out in order", got[d], n);
    end
    // R6: the dual variant never deasserts ready
    chk(low[1] == 0, "R6 dual in_ready low cycles", low[1], 0);
    repeat (3) @(negedge clk);
    if (exact) begin
      chk(int'(cc[0]) == exp_cycles(1, n), "R5 R7 single cycle count", int'(cc[0]), exp_cycles(1, n));
      chk(int'(cc[1]) == exp_cycles(2, n), "R6 R7 dual cycle count", int'(cc[1]), exp_cycles(2, n));
      chk(low[0] == n - 1, "R5 single stall cycles", low[0], n - 1);
    end
    // R7: count holds after drain
    begin
      int h0 = int'(cc[0]);
      int h1 = int'(cc[1]);
      repeat (5) @(negedge clk);
      chk(int'(cc[0]) == h0 && int'(cc[1]) == h1, "R7 count holds when idle", int'(cc[0]), h0);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    v[0] = 0; v[1] = 0; tg[0] = '0; tg[1] = '0;
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(ov[d] == 1'b0, "R1 out_valid in reset", int'(ov[d]), 0);
      chk(int'(cc[d]) == 0, "R1 count in reset", int'(cc[d]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) chk(rdy[d] == 1'b1, "R1 R3 ready after reset", int'(rdy[d]), 1);

    // R4: lone tag takes 7 cycles in both variants
    run_batch(1, 0, 1);
    chk(int'(cc[0]) == 7, "R4 lone tag single", int'(cc[0]), 7);
    chk(int'(cc[1]) == 7, "R4 lone tag dual", int'(cc[1]), 7);
    // R8: each new batch restarts the count
    run_batch(2, 0, 1);
    run_batch(5, 0, 1);
    run_batch(12, 0, 1);
    run_batch(3, 0, 1);
    chk(int'(cc[0]) == exp_cycles(1, 3), "R8 restart single", int'(cc[0]), exp_cycles(1, 3));
    chk(int'(cc[1]) == exp_cycles(2, 3), "R8 restart dual", int'(cc[1]), exp_cycles(2, 3));

    // R2 R3: random gaps in the input
    for (int b = 0; b < 4; b++) run_batch(20, 35, 0);
    run_batch(4, 0, 1);

    // R1: reset in the middle of a batch
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      v[0] = 1; v[1] = 1; tg[0] = TAG_W'(c + 1); tg[1] = TAG_W'(c + 1);
    end
    @(negedge clk);
    rst_n = 1'b0; v[0] = 0; v[1] = 0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(ov[d] == 1'b0 && int'(cc[d]) == 0, "R1 mid-batch reset clears", int'(cc[d]) + int'(ov[d]), 0);
      chk(rdy[d] == 1'b1, "R1 ready after mid-batch reset", int'(rdy[d]), 1);
    end
    rst_n = 1'b1;
    begin
      int stray = 0;
      repeat (12) begin
        @(negedge clk);
        if (ov[0] || ov[1]) stray++;
      end
      chk(stray == 0, "R1 no output after reset", stray, 0);
    end
    finish_run();
  end
endmodule